// File: doc/BRIEF.md
# Dual-Reload PWM Countdown Timer

This block is a single-channel down-counter that can act as a PWM source. Software programs two reload values and a control word through a small word-wide register port. In PWM mode the output spends a number of clocks low, set by the low-reload value, and then a number of clocks high, set by the high-reload value. It repeats that cycle for as long as the timer is enabled. With PWM mode off, the output toggles each time the low-reload value runs out, which gives a square wave with a 50% duty cycle. In that mode the high-reload value has no effect.

Setting the enable bit while it is clear loads the low-reload value into the counter. The waveform then always begins with its low phase. Clearing enable freezes the counter and forces the output low. An end-of-count strobe marks every cycle in which the running counter stands at zero. The control word, both reload values and the live count can all be read back.

Top module: `dual_phase_pwm_timer`

## Requirements
- R1: After reset, every readable location returns 0, and both `pwm_out` and `eoc` are low.
- R2: The control word at address 0 has these bits: run at bit 0, auto-reload at bit 1 and PWM at bit 3. All other bits are ignored on write and read back as zero.
- R3: Writing the control word with bit 0 set while the timer is stopped loads the low-reload value (address 1). The output is then low for exactly low-reload + 1 clocks, counting from the first clock after the write.
- R4: In PWM mode the high phase lasts exactly high-reload (address 2) + 1 clocks, and the output then returns to a low phase of low-reload + 1 clocks.
- R5: With PWM clear, both phases last low-reload + 1 clocks, whatever the high-reload value is.
- R6: `eoc` is high for exactly one clock per phase: the last clock of that phase, when the count is zero.
- R7: With auto-reload set, the counter reloads from the reload registers at zero. With auto-reload clear, it reloads to all ones (0xFFFFFFFF at address 3).
- R8: Clearing bit 0 stops the count; the value at address 3 holds. `pwm_out` and `eoc` stay low while stopped.
- R9: Setting bit 0 again restarts the waveform from a fresh low phase of low-reload + 1 clocks.
- R10: A reload value written while the timer runs does not change the current phase. It is used from the next reload.
- R11: A reload value of 0 gives a phase of exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register select: 0 control, 1 low reload, 2 high reload, 3 live count (read only) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | Timer waveform output |
| eoc | output | 1 | End-of-count strobe |

## Verification
The bench measures the length of each phase in clocks, for zero-valued and non-zero reloads, with PWM on and off. An off-by-one counter would show up as phases one clock too long or too short. A design that starts high after enable, or that uses the high-reload value in square-wave mode, would give lengths that do not match the expected ones. Directed tests check several more cases:
- A reload rewritten in the middle of a phase must not shorten that phase.
- The count must freeze at a known value when the timer is stopped.
- Re-enabling must restart with a low phase.
- A free-running reload must land on all ones.

A design that reloads immediately, keeps counting while stopped, or resumes where it left off fails these tests.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LOW   = 2'd1,
    REG_HIGH  = 2'd2,
    REG_COUNT = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_AUTO_BIT = 1;
  localparam int CTRL_PWM_BIT  = 3;

  typedef struct packed {
    logic pwm;
    logic auto_rl;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt_now,
  output logic [W-1:0] rdata,
  output ctrl_t        ctrl,
  output logic [W-1:0] low_rl,
  output logic [W-1:0] high_rl,
  output logic         start
);
  function automatic ctrl_t decode_ctrl(input logic [W-1:0] d);
    ctrl_t c;
    c.run     = d[CTRL_RUN_BIT];
    c.auto_rl = d[CTRL_AUTO_BIT];
    c.pwm     = d[CTRL_PWM_BIT];
    return c;
  endfunction

  function automatic logic [W-1:0] encode_ctrl(input ctrl_t c);
    logic [W-1:0] r;
    r = '0;
    r[CTRL_RUN_BIT]  = c.run;
    r[CTRL_AUTO_BIT] = c.auto_rl;
    r[CTRL_PWM_BIT]  = c.pwm;
    return r;
  endfunction

  logic wr_ctrl, wr_low, wr_high;
  ctrl_t ctrl_new;

  assign wr_ctrl  = wr_en && (addr == REG_CTRL);
  assign wr_low   = wr_en && (addr == REG_LOW);
  assign wr_high  = wr_en && (addr == REG_HIGH);
  assign ctrl_new = decode_ctrl(wdata);
  // a stopped-to-running write is the only event that arms the counter
  assign start    = wr_ctrl && ctrl_new.run && !ctrl.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      low_rl  <= '0;
      high_rl <= '0;
    end else begin
      if (wr_ctrl) ctrl    <= ctrl_new;
      if (wr_low)  low_rl  <= wdata;
      if (wr_high) high_rl <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      REG_CTRL: rdata = encode_ctrl(ctrl);
      REG_LOW:  rdata = low_rl;
      REG_HIGH: rdata = high_rl;
      default:  rdata = cnt_now;
    endcase
  end

  assert_low_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_low |=> low_rl == $past(wdata));

  assert_high_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_high |=> high_rl == $past(wdata));
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
  import ptmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrl_t        ctrl,
  input  logic [W-1:0] low_rl,
  input  logic [W-1:0] high_rl,
  input  logic         start,
  output logic [W-1:0] cnt,
  output logic         phase_hi,
  output logic         running,
  output logic         zero_hit
);
  localparam logic [W-1:0] ALL_ONES = '1;

  // value taken at a reload, given the phase that is about to begin
  function automatic logic [W-1:0] pick_reload(input ctrl_t c, input logic next_hi,
                                               input logic [W-1:0] lo,
                                               input logic [W-1:0] hi);
    if (!c.auto_rl)            return ALL_ONES;
    else if (c.pwm && next_hi) return hi;
    else                       return lo;
  endfunction

  logic         next_hi;
  logic [W-1:0] reload_val;

  assign running    = ctrl.run;
  assign zero_hit   = running && (cnt == '0);
  assign next_hi    = !phase_hi;
  assign reload_val = pick_reload(ctrl, next_hi, low_rl, high_rl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase_hi <= 1'b0;
    end else if (start) begin
      cnt      <= low_rl;
      phase_hi <= 1'b0;
    end else if (!running) begin
      phase_hi <= 1'b0;
    end else if (zero_hit) begin
      cnt      <= reload_val;
      phase_hi <= next_hi;
    end else begin
      cnt      <= cnt - W'(1);
    end
  end

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!phase_hi && cnt == $past(low_rl)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(cnt));

  assert_zero_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && zero_hit) |=> (!running || phase_hi != $past(phase_hi)));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !zero_hit) |=> cnt == $past(cnt) - W'(1));
endmodule

// File: rtl/dual_phase_pwm_timer.sv
module dual_phase_pwm_timer
  import ptmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         pwm_out,
  output logic         eoc
);
  ctrl_t        ctrl;
  logic [W-1:0] low_rl, high_rl, cnt;
  logic         start, phase_hi, running, zero_hit;

  ptmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt_now(cnt), .rdata(rdata), .ctrl(ctrl), .low_rl(low_rl),
    .high_rl(high_rl), .start(start)
  );

  ptmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .low_rl(low_rl), .high_rl(high_rl),
    .start(start), .cnt(cnt), .phase_hi(phase_hi), .running(running),
    .zero_hit(zero_hit)
  );

  assign pwm_out = running && phase_hi;
  assign eoc     = zero_hit;

  assert_stopped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!pwm_out && !eoc));
endmodule

// File: tb/sim_dual_phase_pwm_timer.sv
module sim_dual_phase_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        pwm_out, eoc;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dual_phase_pwm_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out), .eoc(eoc)
  );

  // columns: control word, low reload, high reload, expected low len, expected high len
  localparam logic [31:0] VEC [0:5][0:4] = '{
    '{32'hB, 32'd3, 32'd5, 32'd4, 32'd6},
    '{32'hB, 32'd0, 32'd0, 32'd1, 32'd1},
    '{32'hB, 32'd0, 32'd4, 32'd1, 32'd5},
    '{32'hB, 32'd7, 32'd1, 32'd8, 32'd2},
    '{32'h3, 32'd4, 32'd9, 32'd5, 32'd5},
    '{32'h3, 32'd0, 32'd6, 32'd1, 32'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the write applied
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  // counts samples at level lvl from now; stops on the first differing sample
  task automatic run_len(input logic lvl, output int n, output int ne);
    n = 0; ne = 0;
    while (pwm_out == lvl && n < 5000) begin
      if (eoc) ne++;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, ne;
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reset readback", d, 32'h0);
    end
    check("R1 reset pwm_out", {31'd0, pwm_out}, 32'd0);
    check("R1 reset eoc", {31'd0, eoc}, 32'd0);

    // table of waveform vectors: R3 R4 R5 R6 R7 R11
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, 32'h0);
      wr(2'd1, VEC[i][1]);
      wr(2'd2, VEC[i][2]);
      wr(2'd0, VEC[i][0]);
      run_len(1'b0, n, ne);
      check("R3 first low phase length", 32'(n), VEC[i][3]);
      check("R6 eoc per low phase", 32'(ne), 32'd1);
      run_len(1'b1, n, ne);
      check(VEC[i][0][3] ? "R4 high phase length" : "R5 square-wave second phase",
            32'(n), VEC[i][4]);
      check("R6 eoc per high phase", 32'(ne), 32'd1);
      run_len(1'b0, n, ne);
      check("R7 reloaded low phase length", 32'(n), VEC[i][3]);
    end

    // R2 control layout
    wr(2'd0, 32'h0);
    wr(2'd0, 32'hFFFF_FFF6);
    rd(2'd0, d);
    check("R2 control readback no run", d, 32'h2);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    check("R2 control readback all", d, 32'hB);
    wr(2'd0, 32'h0);

    // R8 stop holds the count
    wr(2'd1, 32'd2);
    wr(2'd2, 32'd20);
    wr(2'd0, 32'hB);
    repeat (4) @(negedge clk);
    wr(2'd0, 32'h0);
    rd(2'd3, d);
    check("R8 count frozen on stop", d, 32'd18);
    check("R8 output low when stopped", {31'd0, pwm_out}, 32'd0);
    repeat (4) @(negedge clk);
    rd(2'd3, d);
    check("R8 count still frozen", d, 32'd18);
    check("R8 eoc low when stopped", {31'd0, eoc}, 32'd0);

    // R9 restart from a fresh low phase
    wr(2'd0, 32'hB);
    run_len(1'b0, n, ne);
    check("R9 restart low length", 32'(n), 32'd3);
    run_len(1'b1, n, ne);
    check("R9 restart high length", 32'(n), 32'd21);

    // R10 rewrite of low reload during a running low phase
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd4);
    wr(2'd2, 32'd4);
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd1);
    run_len(1'b0, n, ne);
    check("R10 current low phase unchanged", 32'(n), 32'd4);
    run_len(1'b1, n, ne);
    check("R10 high phase", 32'(n), 32'd5);
    run_len(1'b0, n, ne);
    check("R10 new low value at next reload", 32'(n), 32'd2);

    // R7 free-running reload to all ones
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h9);
    rd(2'd3, d);
    check("R7 free-run initial load", d, 32'd2);
    repeat (2) @(negedge clk);
    check("R6 eoc at zero free-run", {31'd0, eoc}, 32'd1);
    @(negedge clk);
    rd(2'd3, d);
    check("R7 free-run reload all ones", d, 32'hFFFF_FFFF);
    check("R7 free-run output toggled", {31'd0, pwm_out}, 32'd1);
    @(negedge clk);
    rd(2'd3, d);
    check("R7 free-run counts down", d, 32'hFFFF_FFFE);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule